// File: doc/BRIEF.md
# Non-Blocking Miss Tracking Cache Controller

This block is the control core of a small direct-mapped, read-only data cache that keeps taking processor loads while block fetches are still in flight. Each outstanding fetch owns one slot in a small tracking table. The slot records the block address and the list of loads waiting on that block. A load that finds its block resident gets its answer in the next cycle, whatever fetches are pending. A load that misses either claims a free slot, which raises one memory fetch, or joins the slot that already fetches its block, which raises none.

Each processor load carries a tag, and its answer carries the same tag back. Answers can therefore come back in a different order from the loads. The memory side gets a block address and a slot index, and it answers with a whole line that carries the same index. When a line arrives, the controller writes it into the cache. It then returns the waiting loads of that slot, one per cycle in the order they joined, and frees the slot. Addresses are word addresses. Bits [1:0] select the word in a four-word line, bits [4:2] select one of eight lines, and the rest is the line tag.

Top module: `nb_miss_ctrl`

## Requirements
- R1: After reset, req_ready_o is 1, rsp_valid_o is 0, mem_req_valid_o is 0, mem_rsp_ready_o is 1, and every line reads as empty.
- R2: A load accepted to a resident block that has no pending fetch gives rsp_valid_o one cycle later. That response carries the load's tag and the word at bits [off*32 +: 32] of the line. This holds while other fetches are pending.
- R3: A load that misses on a block with no pending fetch claims the lowest free slot. It raises mem_req_valid_o with the block address (req_addr_i[11:2]) and the slot index, and the request is held until mem_req_ready_i is 1. req_ready_o stays 1 for the following loads.
- R4: Up to four distinct blocks can be outstanding at once, each with exactly one memory request.
- R5: A load to a block that already has a pending slot joins that slot and raises no new memory request. At most one slot ever tracks a given block.
- R6: req_ready_o is 0 when the presented load misses on a new block while all four slots are taken, or when the load targets a pending block whose slot already holds four waiters. A hit is still accepted while all slots are taken.
- R7: A line accepted on the memory response port (the word k at bits [k*32 +: 32]) is written to the cache line chosen by the slot's block. Starting the next cycle, the slot's waiters are returned one per cycle in joining order, each with its own word.
- R8: While a slot drains, req_ready_o and mem_rsp_ready_o are 0. The slot is free again once its last waiter is returned.
- R9: A pending slot takes precedence over the line lookup. A block sharing a line index with the resident block still misses while the resident block keeps hitting. After the fill, the old block misses.
- R10: A fill for a later miss may complete before an earlier one, so tagged answers return out of request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor load valid |
| req_ready_o | output | 1 | Load can be accepted this cycle |
| req_addr_i | input | 12 | Word address of the load |
| req_tag_i | input | 4 | Load tag |
| rsp_valid_o | output | 1 | Load answer valid |
| rsp_tag_o | output | 4 | Tag of the answered load |
| rsp_data_o | output | 32 | Loaded word |
| mem_req_valid_o | output | 1 | Block fetch request valid |
| mem_req_ready_i | input | 1 | Memory takes the fetch request |
| mem_req_blk_o | output | 10 | Block address to fetch |
| mem_req_id_o | output | 2 | Slot index of the fetch |
| mem_rsp_valid_i | input | 1 | Line returned by memory |
| mem_rsp_ready_o | output | 1 | Controller can take a line |
| mem_rsp_id_i | input | 2 | Slot index of the returned line |
| mem_rsp_line_i | input | 128 | Returned line, word k at bits [k*32 +: 32] |

## Verification
The main function is tried with a single cold miss, with repeated misses to one block, and with misses to distinct blocks. The first shows that a fetch is raised and the processor port stays open. The second shows whether joining replaces a second fetch and whether waiters drain in joining order. The third separates a true multi-miss tracker from a one-miss one, and filling in reverse order shows that answers follow the fills and not the requests. Hits placed between a miss and its fill, loads offered during a drain, loads offered with all slots or all waiter places taken, and two blocks sharing one line index tell apart stalling, precedence and back-pressure faults.

// File: rtl/nbm_pkg.sv
package nbm_pkg;
  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_DRAIN = 1'b1
  } seq_state_e;
endpackage

// File: rtl/nbm_line_store.sv
module nbm_line_store #(
  parameter int LINES      = 8,
  parameter int LINE_WORDS = 4,
  parameter int DATA_W     = 32,
  parameter int LTAG_W     = 5,
  localparam int IDX_W     = $clog2(LINES),
  localparam int OFF_W     = $clog2(LINE_WORDS),
  localparam int LINE_W    = LINE_WORDS * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  lk_idx_i,
  input  logic [LTAG_W-1:0] lk_tag_i,
  input  logic [OFF_W-1:0]  lk_off_i,
  output logic              lk_hit_o,
  output logic [DATA_W-1:0] lk_word_o,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [OFF_W-1:0]  rd_off_i,
  output logic [DATA_W-1:0] rd_word_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [LTAG_W-1:0] wr_tag_i,
  input  logic [LINE_W-1:0] wr_line_i
);
  logic [LINES-1:0]  ok_q;
  logic [LTAG_W-1:0] tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES][LINE_WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_q <= '0;
      for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
    end else if (wr_en_i) begin
      ok_q[wr_idx_i]  <= 1'b1;
      tag_q[wr_idx_i] <= wr_tag_i;
    end
  end

  // data array carries no reset; validity lives in ok_q
  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      for (int k = 0; k < LINE_WORDS; k++)
        dat_q[wr_idx_i][k] <= wr_line_i[k*DATA_W +: DATA_W];
    end
  end

  assign lk_hit_o  = ok_q[lk_idx_i] && (tag_q[lk_idx_i] == lk_tag_i);
  assign lk_word_o = dat_q[lk_idx_i][lk_off_i];
  assign rd_word_o = dat_q[rd_idx_i][rd_off_i];
endmodule

// File: rtl/nbm_miss_table.sv
module nbm_miss_table #(
  parameter int N       = 4,
  parameter int WAIT_N  = 4,
  parameter int BLK_W   = 10,
  parameter int OFF_W   = 2,
  parameter int TAG_W   = 4,
  localparam int ID_W   = $clog2(N),
  localparam int CNT_W  = $clog2(WAIT_N + 1),
  localparam int SLOT_W = $clog2(WAIT_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BLK_W-1:0]  look_blk_i,
  output logic              match_o,
  output logic              match_room_o,
  output logic              free_avail_o,
  input  logic              ins_i,
  input  logic [TAG_W-1:0]  ins_tag_i,
  input  logic [OFF_W-1:0]  ins_off_i,
  output logic              mreq_valid_o,
  output logic [ID_W-1:0]   mreq_id_o,
  output logic [BLK_W-1:0]  mreq_blk_o,
  input  logic              mreq_ready_i,
  input  logic              fill_en_i,
  input  logic [ID_W-1:0]   fill_id_i,
  output logic [BLK_W-1:0]  fill_blk_o,
  input  logic [ID_W-1:0]   drn_id_i,
  input  logic [SLOT_W-1:0] drn_slot_i,
  output logic [TAG_W-1:0]  drn_tag_o,
  output logic [OFF_W-1:0]  drn_off_o,
  output logic [BLK_W-1:0]  drn_blk_o,
  output logic [CNT_W-1:0]  drn_cnt_o,
  input  logic              free_i
);
  logic             vld_q [N];
  logic             iss_q [N];
  logic [BLK_W-1:0] blk_q [N];
  logic [CNT_W-1:0] cnt_q [N];
  logic [TAG_W-1:0] wtag_q [N][WAIT_N];
  logic [OFF_W-1:0] woff_q [N][WAIT_N];

  logic [N-1:0]    hit_vec;
  logic [ID_W-1:0] match_idx;
  logic [ID_W-1:0] alloc_idx;
  logic            do_alloc, do_merge;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = vld_q[g] && (blk_q[g] == look_blk_i);
  end

  always_comb begin
    match_o   = 1'b0;
    match_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        match_o   = 1'b1;
        match_idx = ID_W'(i);
      end
    end
  end

  always_comb begin
    free_avail_o = 1'b0;
    alloc_idx    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        free_avail_o = 1'b1;
        alloc_idx    = ID_W'(i);
      end
    end
  end

  always_comb begin
    mreq_valid_o = 1'b0;
    mreq_id_o    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vld_q[i] && !iss_q[i]) begin
        mreq_valid_o = 1'b1;
        mreq_id_o    = ID_W'(i);
      end
    end
  end

  assign mreq_blk_o   = blk_q[mreq_id_o];
  assign match_room_o = cnt_q[match_idx] != CNT_W'(WAIT_N);
  assign do_merge     = ins_i && match_o;
  assign do_alloc     = ins_i && !match_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) begin
        vld_q[i] <= 1'b0;
        iss_q[i] <= 1'b0;
        blk_q[i] <= '0;
        cnt_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (free_i && drn_id_i == ID_W'(i)) vld_q[i] <= 1'b0;
        if (mreq_valid_o && mreq_ready_i && mreq_id_o == ID_W'(i)) iss_q[i] <= 1'b1;
        if (do_alloc && alloc_idx == ID_W'(i)) begin
          vld_q[i] <= 1'b1;
          iss_q[i] <= 1'b0;
          blk_q[i] <= look_blk_i;
          cnt_q[i] <= CNT_W'(1);
        end
        if (do_merge && match_idx == ID_W'(i)) cnt_q[i] <= cnt_q[i] + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < N; i++) begin
      if (do_alloc && alloc_idx == ID_W'(i)) begin
        wtag_q[i][0] <= ins_tag_i;
        woff_q[i][0] <= ins_off_i;
      end
      if (do_merge && match_idx == ID_W'(i)) begin
        wtag_q[i][SLOT_W'(cnt_q[i])] <= ins_tag_i;
        woff_q[i][SLOT_W'(cnt_q[i])] <= ins_off_i;
      end
    end
  end

  assign fill_blk_o = blk_q[fill_id_i];
  assign drn_tag_o  = wtag_q[drn_id_i][drn_slot_i];
  assign drn_off_o  = woff_q[drn_id_i][drn_slot_i];
  assign drn_blk_o  = blk_q[drn_id_i];
  assign drn_cnt_o  = cnt_q[drn_id_i];

  assert_one_slot_per_block_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
  assert_insert_has_room_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_i |-> (match_o ? match_room_o : free_avail_o));
  assert_fill_for_issued_slot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_en_i |-> (vld_q[fill_id_i] && iss_q[fill_id_i]));
endmodule

// File: rtl/nbm_rsp_seq.sv
module nbm_rsp_seq #(
  parameter int N       = 4,
  parameter int WAIT_N  = 4,
  localparam int ID_W   = $clog2(N),
  localparam int CNT_W  = $clog2(WAIT_N + 1),
  localparam int SLOT_W = $clog2(WAIT_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mem_rsp_valid_i,
  input  logic [ID_W-1:0]   mem_rsp_id_i,
  output logic              rsp_ready_o,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [ID_W-1:0]   id_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              step_o,
  output logic              last_o
);
  import nbm_pkg::*;

  seq_state_e        state_q;
  logic [ID_W-1:0]   id_q;
  logic [SLOT_W-1:0] ptr_q;

  assign rsp_ready_o = state_q == SEQ_IDLE;
  assign step_o      = state_q == SEQ_DRAIN;
  assign last_o      = step_o && ((CNT_W'(ptr_q) + CNT_W'(1)) == cnt_i);
  assign id_o        = id_q;
  assign slot_o      = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      id_q    <= '0;
      ptr_q   <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: if (mem_rsp_valid_i) begin
          state_q <= SEQ_DRAIN;
          id_q    <= mem_rsp_id_i;
          ptr_q   <= '0;
        end
        SEQ_DRAIN: begin
          if (last_o) state_q <= SEQ_IDLE;
          else        ptr_q   <= ptr_q + SLOT_W'(1);
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assert_drain_within_waiters_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> (CNT_W'(ptr_q) < cnt_i));
  assert_drain_id_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && !last_o) |=> (step_o && $stable(id_q)));
endmodule

// File: rtl/nb_miss_ctrl.sv
module nb_miss_ctrl #(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int TAG_W      = 4,
  parameter int LINES      = 8,
  parameter int LINE_WORDS = 4,
  parameter int MSHR_N     = 4,
  parameter int WAIT_N     = 4,
  localparam int OFF_W     = $clog2(LINE_WORDS),
  localparam int IDX_W     = $clog2(LINES),
  localparam int BLK_W     = ADDR_W - OFF_W,
  localparam int LTAG_W    = BLK_W - IDX_W,
  localparam int ID_W      = $clog2(MSHR_N),
  localparam int LINE_W    = LINE_WORDS * DATA_W,
  localparam int CNT_W     = $clog2(WAIT_N + 1),
  localparam int SLOT_W    = $clog2(WAIT_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [TAG_W-1:0]  req_tag_i,
  output logic              rsp_valid_o,
  output logic [TAG_W-1:0]  rsp_tag_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [BLK_W-1:0]  mem_req_blk_o,
  output logic [ID_W-1:0]   mem_req_id_o,
  input  logic              mem_rsp_valid_i,
  output logic              mem_rsp_ready_o,
  input  logic [ID_W-1:0]   mem_rsp_id_i,
  input  logic [LINE_W-1:0] mem_rsp_line_i
);
  logic [BLK_W-1:0]  req_blk;
  logic [OFF_W-1:0]  req_off;
  logic              lk_hit, hit, match, room, free_avail;
  logic [DATA_W-1:0] lk_word, drn_word;
  logic              acc, ins, fill_en;
  logic [BLK_W-1:0]  fill_blk, drn_blk;
  logic [ID_W-1:0]   drn_id;
  logic [SLOT_W-1:0] drn_slot;
  logic [TAG_W-1:0]  drn_tag;
  logic [OFF_W-1:0]  drn_off;
  logic [CNT_W-1:0]  drn_cnt;
  logic              step, last, seq_idle;

  logic              rsp_valid_q;
  logic [TAG_W-1:0]  rsp_tag_q;
  logic [DATA_W-1:0] rsp_data_q;

  assign req_blk = req_addr_i[ADDR_W-1:OFF_W];
  assign req_off = req_addr_i[OFF_W-1:0];

  // a pending slot for the block overrides whatever the line holds
  assign hit         = lk_hit && !match;
  assign req_ready_o = seq_idle && (match ? room : (hit || free_avail));
  assign acc         = req_valid_i && req_ready_o;
  assign ins         = acc && !hit;
  assign fill_en     = mem_rsp_valid_i && seq_idle;
  assign mem_rsp_ready_o = seq_idle;

  nbm_line_store #(
    .LINES(LINES), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W), .LTAG_W(LTAG_W)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lk_idx_i  (req_blk[IDX_W-1:0]),
    .lk_tag_i  (req_blk[BLK_W-1:IDX_W]),
    .lk_off_i  (req_off),
    .lk_hit_o  (lk_hit),
    .lk_word_o (lk_word),
    .rd_idx_i  (drn_blk[IDX_W-1:0]),
    .rd_off_i  (drn_off),
    .rd_word_o (drn_word),
    .wr_en_i   (fill_en),
    .wr_idx_i  (fill_blk[IDX_W-1:0]),
    .wr_tag_i  (fill_blk[BLK_W-1:IDX_W]),
    .wr_line_i (mem_rsp_line_i)
  );

  nbm_miss_table #(
    .N(MSHR_N), .WAIT_N(WAIT_N), .BLK_W(BLK_W), .OFF_W(OFF_W), .TAG_W(TAG_W)
  ) u_table (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .look_blk_i   (req_blk),
    .match_o      (match),
    .match_room_o (room),
    .free_avail_o (free_avail),
    .ins_i        (ins),
    .ins_tag_i    (req_tag_i),
    .ins_off_i    (req_off),
    .mreq_valid_o (mem_req_valid_o),
    .mreq_id_o    (mem_req_id_o),
    .mreq_blk_o   (mem_req_blk_o),
    .mreq_ready_i (mem_req_ready_i),
    .fill_en_i    (fill_en),
    .fill_id_i    (mem_rsp_id_i),
    .fill_blk_o   (fill_blk),
    .drn_id_i     (drn_id),
    .drn_slot_i   (drn_slot),
    .drn_tag_o    (drn_tag),
    .drn_off_o    (drn_off),
    .drn_blk_o    (drn_blk),
    .drn_cnt_o    (drn_cnt),
    .free_i       (last)
  );

  nbm_rsp_seq #(.N(MSHR_N), .WAIT_N(WAIT_N)) u_seq (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rsp_id_i    (mem_rsp_id_i),
    .rsp_ready_o     (seq_idle),
    .cnt_i           (drn_cnt),
    .id_o            (drn_id),
    .slot_o          (drn_slot),
    .step_o          (step),
    .last_o          (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_tag_q   <= '0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= step || (acc && hit);
      if (step) begin
        rsp_tag_q  <= drn_tag;
        rsp_data_q <= drn_word;
      end else if (acc && hit) begin
        rsp_tag_q  <= req_tag_i;
        rsp_data_q <= lk_word;
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_tag_o   = rsp_tag_q;
  assign rsp_data_o  = rsp_data_q;

  assert_hit_next_cycle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && hit) |=> (rsp_valid_o && rsp_tag_o == $past(req_tag_i)));
  assert_fetch_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> mem_req_valid_o);
  assert_no_accept_in_drain_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |-> !(acc || fill_en));
endmodule

// File: tb/sim_nb_miss_ctrl.sv
module sim_nb_miss_ctrl;
  localparam int N = 4, WN = 4, LINES = 8;

  logic         clk = 1'b0, rst_ni = 1'b0;
  logic         req_valid_i = 1'b0, req_ready_o;
  logic [11:0]  req_addr_i = '0;
  logic [3:0]   req_tag_i = '0, rsp_tag_o;
  logic         rsp_valid_o;
  logic [31:0]  rsp_data_o;
  logic         mem_req_valid_o, mem_req_ready_i = 1'b1;
  logic [9:0]   mem_req_blk_o;
  logic [1:0]   mem_req_id_o, mem_rsp_id_i = '0;
  logic         mem_rsp_valid_i = 1'b0, mem_rsp_ready_o;
  logic [127:0] mem_rsp_line_i = '0;

  always #2 clk = ~clk;

  nb_miss_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_addr_i(req_addr_i), .req_tag_i(req_tag_i),
    .rsp_valid_o(rsp_valid_o), .rsp_tag_o(rsp_tag_o), .rsp_data_o(rsp_data_o),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
    .mem_req_blk_o(mem_req_blk_o), .mem_req_id_o(mem_req_id_o),
    .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_ready_o(mem_rsp_ready_o),
    .mem_rsp_id_i(mem_rsp_id_i), .mem_rsp_line_i(mem_rsp_line_i)
  );

  int    checks = 0, fails = 0, mem_reqs = 0;
  string cur = "R1";
  int    rsp_seen[$];

  // behavioural reference state
  bit          m_ok[LINES];
  int          m_tag[LINES];
  bit          e_v[N], e_iss[N];
  int          e_blk[N];
  int          e_q[N][$];
  bit          m_busy = 0;
  int          m_drn = 0;
  bit          x_rv = 0;
  int          x_tag = 0;
  logic [31:0] x_data = '0;

  function automatic logic [31:0] word_of(int blk, int k);
    return 32'hA000_0000 | 32'(blk << 8) | 32'(k);
  endfunction

  function automatic int find_pend(int blk);
    for (int i = 0; i < N; i++) if (e_v[i] && e_blk[i] == blk) return i;
    return -1;
  endfunction

  function automatic bit m_hit(int addr);
    int b = addr >> 2;
    if (find_pend(b) >= 0) return 0;
    return m_ok[b % LINES] && m_tag[b % LINES] == b / LINES;
  endfunction

  function automatic bit m_ready(int addr);
    int p = find_pend(addr >> 2);
    if (m_busy) return 0;
    if (p >= 0) return e_q[p].size() < WN;
    if (m_hit(addr)) return 1;
    for (int i = 0; i < N; i++) if (!e_v[i]) return 1;
    return 0;
  endfunction

  function automatic int m_mreq();
    for (int i = 0; i < N; i++) if (e_v[i] && !e_iss[i]) return i;
    return -1;
  endfunction

  task automatic chk(bit ok, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", cur, what, act, exp);
    end
  endtask

  task automatic tick();
    int  a  = int'(req_addr_i);
    bit  r  = m_ready(a);
    bit  h  = m_hit(a);
    int  p  = find_pend(a >> 2);
    int  mr = m_mreq();
    bit  busy_pre = m_busy;
    bit  acc;
    #1;
    chk(req_ready_o === r, "req_ready_o", 64'(req_ready_o), 64'(r));
    if (mem_req_valid_o === 1'b1 && mem_req_ready_i) mem_reqs++;
    @(posedge clk);
    acc = req_valid_i && r;
    if (busy_pre) begin
      int w = e_q[m_drn].pop_front();
      x_rv = 1; x_tag = w >> 4; x_data = word_of(e_blk[m_drn], w & 15);
      if (e_q[m_drn].size() == 0) begin e_v[m_drn] = 0; m_busy = 0; end
    end else if (acc && h) begin
      x_rv = 1; x_tag = int'(req_tag_i); x_data = word_of(a >> 2, a & 3);
    end else x_rv = 0;
    if (mr >= 0 && mem_req_ready_i) e_iss[mr] = 1;
    if (acc && !h) begin
      if (p >= 0) e_q[p].push_back(int'(req_tag_i) * 16 + (a & 3));
      else begin
        for (int i = 0; i < N; i++) if (!e_v[i]) begin
          e_v[i] = 1; e_iss[i] = 0; e_blk[i] = a >> 2;
          e_q[i].delete();
          e_q[i].push_back(int'(req_tag_i) * 16 + (a & 3));
          break;
        end
      end
    end
    if (mem_rsp_valid_i && !busy_pre) begin
      int b = e_blk[mem_rsp_id_i];
      m_ok[b % LINES] = 1; m_tag[b % LINES] = b / LINES;
      m_busy = 1; m_drn = int'(mem_rsp_id_i);
    end
    #1;
    chk(rsp_valid_o === x_rv, "rsp_valid_o", 64'(rsp_valid_o), 64'(x_rv));
    if (x_rv) begin
      rsp_seen.push_back(x_tag);
      chk(rsp_tag_o === 4'(x_tag), "rsp_tag_o", 64'(rsp_tag_o), 64'(x_tag));
      chk(rsp_data_o === x_data, "rsp_data_o", 64'(rsp_data_o), 64'(x_data));
    end
    mr = m_mreq();
    chk(mem_req_valid_o === (mr >= 0), "mem_req_valid_o", 64'(mem_req_valid_o), 64'(mr >= 0));
    if (mr >= 0) begin
      chk(mem_req_id_o === 2'(mr), "mem_req_id_o", 64'(mem_req_id_o), 64'(mr));
      chk(mem_req_blk_o === 10'(e_blk[mr]), "mem_req_blk_o", 64'(mem_req_blk_o), 64'(e_blk[mr]));
    end
    chk(mem_rsp_ready_o === !m_busy, "mem_rsp_ready_o", 64'(mem_rsp_ready_o), 64'(!m_busy));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic load(int blk, int off, int tag);
    req_valid_i = 1; req_addr_i = 12'(blk * 4 + off); req_tag_i = 4'(tag);
    tick();
    req_valid_i = 0;
  endtask

  task automatic fill(int blk);
    int id = find_pend(blk);
    mem_rsp_valid_i = 1; mem_rsp_id_i = 2'(id);
    for (int k = 0; k < 4; k++) mem_rsp_line_i[k*32 +: 32] = word_of(blk, k);
    tick();
    mem_rsp_valid_i = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    #0;
    cur = "R1";
    chk(req_ready_o === 1'b1, "reset ready", 64'(req_ready_o), 1);
    chk(rsp_valid_o === 1'b0, "reset rsp_valid", 64'(rsp_valid_o), 0);
    chk(mem_req_valid_o === 1'b0, "reset mem_req_valid", 64'(mem_req_valid_o), 0);
    chk(mem_rsp_ready_o === 1'b1, "reset mem_rsp_ready", 64'(mem_rsp_ready_o), 1);
    idle(1);

    cur = "R3"; load(5, 1, 1);
    cur = "R5"; load(5, 2, 2); idle(1);
    chk(mem_reqs == 1, "merge fetch count R5", 64'(mem_reqs), 1);
    cur = "R4"; load(9, 0, 3); idle(1);
    chk(mem_reqs == 2, "two outstanding fetches R4", 64'(mem_reqs), 2);
    cur = "R10"; rsp_seen.delete(); fill(9); idle(2);
    chk(rsp_seen.size() > 0 && rsp_seen[0] == 3, "later miss answered first R10",
        64'(rsp_seen.size() > 0 ? rsp_seen[0] : -1), 3);
    cur = "R7"; rsp_seen.delete(); fill(5);
    cur = "R8"; load(9, 1, 12); idle(3);
    cur = "R7";
    chk(rsp_seen.size() >= 2 && rsp_seen[0] == 1 && rsp_seen[1] == 2, "waiter order R7",
        64'(rsp_seen.size() >= 2 ? rsp_seen[0] * 16 + rsp_seen[1] : -1), 64'h12);

    cur = "R2"; load(5, 3, 4); load(9, 1, 5); idle(1);
    cur = "R3"; load(20, 0, 6); load(5, 0, 7); idle(1); fill(20); idle(2);
    mem_req_ready_i = 0; load(50, 2, 8); idle(3); mem_req_ready_i = 1; idle(1);
    fill(50); idle(2);

    cur = "R6";
    load(30, 0, 8); load(31, 1, 9); load(32, 2, 10); load(33, 3, 11);
    load(34, 0, 12); load(5, 2, 13); idle(1);
    fill(32); idle(2); fill(30); idle(2); fill(33); idle(2); fill(31); idle(2);
    for (int k = 0; k < 4; k++) load(40, k, k);
    load(40, 1, 9); idle(1); fill(40); idle(5);

    cur = "R9";
    load(13, 0, 5); load(5, 1, 6); idle(1); fill(13); idle(2);
    load(5, 2, 7); idle(1);
    chk(mem_reqs > 0 && find_pend(5) >= 0, "old block misses after fill R9",
        64'(find_pend(5) >= 0), 1);
    fill(5); idle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule